// File: doc/BRIEF.md
# CRC32C Descriptor Checksum Unit

This unit computes a CRC32C (Castagnoli) checksum over a byte stream that runs beside a copy datapath. It takes one descriptor at a time. Each descriptor carries a flag word, an optional seed, source, destination and result addresses, and an expected checksum word. The unit checks the descriptor before it accepts it. A descriptor that fails the check ends at once with a reject status, consumes no data and leaves the running checksum as it was.

An accepted descriptor consumes data bytes one per cycle over a valid/ready stream until a byte marked last arrives. Three modes exist. Accumulate mode keeps the raw register, so a single checksum can cover several chunks. Store mode produces the final value, together with the address where it belongs: either just after the data or a separate result address. Test mode compares the final value with an expected word. That word comes from the descriptor, or from four bytes that follow the data in the stream. A mismatch is reported as a channel error status. Every descriptor ends with a one-cycle done pulse that carries a status code.

Top module: `crc32c_desc_unit`

## Requirements
- R1: The checksum uses the reflected polynomial 0x82F63B78, starts from 0xFFFFFFFF and is XORed with 0xFFFFFFFF when it is produced. The bytes "123456789" give 0xE3069283. In the result word, bits 7:0 are the first byte on the wire.
- R2: When neither the store nor the test flag is set, the descriptor ends with status OK and no result. The raw register carries over unchanged into the next descriptor.
- R3: Flag bit 3 (0x08) selects store, bit 4 (0x10) selects test and bit 5 (0x20) selects inline. Bits 2:0 are generic flags and have no effect on the checksum.
- R4: A descriptor with both store and test set is rejected. So is a descriptor with inline set but neither store nor test. A rejected descriptor gives done with status REJECT in the cycle after acceptance, takes no stream bytes and leaves the register unchanged.
- R5: A descriptor is rejected when any of bits 63:40 is set in the source address, in the destination address (only when the copy input is 1), or in the result address (only when inline is clear).
- R6: When the seed-valid input is set, the register is loaded with the 32-bit seed before the first data byte. Otherwise it continues from its current value.
- R7: Store mode without inline raises res_valid together with done. It gives res_addr equal to the result address and res_crc equal to the final value.
- R8: Store mode with inline gives res_addr equal to the destination address plus the byte count when copy is 1, or the source address plus the byte count when copy is 0.
- R9: Test mode compares the final value with the descriptor's expected word, or (with inline) with the four stream bytes that follow the data, where the first byte fills bits 7:0. The status is OK on a match and MISMATCH on a difference. Test mode never raises res_valid.
- R10: done is high for exactly one cycle per descriptor. The status codes are OK=0, REJECT=1 and MISMATCH=2. After an accepted store or test descriptor, the register returns to 0xFFFFFFFF.
- R11: desc_ready is high only while the unit is idle. in_ready is high only while data or expected bytes are being taken. The data phase ends with the byte marked last. After reset the unit is idle with done, in_ready and res_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor taken when both high |
| desc_flags | input | 6 | Flag word (store bit 3, test bit 4, inline bit 5) |
| desc_copy | input | 1 | 1 = copy with checksum, 0 = checksum only |
| desc_seed_valid | input | 1 | Load seed before data |
| desc_seed | input | 32 | Seed value |
| desc_src | input | 64 | Source address |
| desc_dst | input | 64 | Destination address |
| desc_res | input | 64 | Separate result address |
| desc_exp | input | 32 | Expected checksum for non-inline test |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte taken when both high |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Last data byte of the descriptor |
| done | output | 1 | One-cycle end-of-descriptor pulse |
| status | output | 2 | OK=0, REJECT=1, MISMATCH=2 |
| res_valid | output | 1 | Store result present |
| res_addr | output | 64 | Where the result is to be written |
| res_crc | output | 32 | Final checksum, bits 7:0 first on the wire |

## Verification
The embedded assertions watch, on every cycle, that done lasts only one cycle, that the two ready outputs are never high together, and that a reject follows a descriptor handshake and leaves the register untouched. They also check that a seed load lands in the register, that a mismatch appears only in test mode, that a result appears only with an OK done, and that the register returns to its initial value after store and test. Only the bench scenarios can show that the checksum values are correct: the chain carried across accumulate descriptors, the inline result addresses for copy and checksum-only descriptors, the inline expected-byte ordering, and the exact set of flag and address combinations that are rejected.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;

    localparam int FLAG_W    = 6;
    localparam int ADDR_W    = 64;
    localparam int ADDR_OK_W = 40;
    localparam int CRC_W     = 32;

    localparam logic [CRC_W-1:0] CRC_POLY   = 32'h82F6_3B78;
    localparam logic [CRC_W-1:0] CRC_INIT   = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] CRC_XOROUT = 32'hFFFF_FFFF;

    localparam int FB_STORE  = 3;
    localparam int FB_TEST   = 4;
    localparam int FB_INLINE = 5;
    localparam logic [FLAG_W-1:0] FLAG_KNOWN = 6'h3F;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_REJECT   = 2'd1,
        ST_MISMATCH = 2'd2
    } status_e;

    typedef enum logic [1:0] {
        MODE_ACCUM = 2'd0,
        MODE_STORE = 2'd1,
        MODE_TEST  = 2'd2
    } mode_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic              copy;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] res;
    } desc_t;

    function automatic logic [CRC_W-1:0] crc32c_byte(input logic [CRC_W-1:0] c,
                                                     input logic [7:0] b);
        logic [CRC_W-1:0] r;
        r = c ^ {{(CRC_W-8){1'b0}}, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic addr_high_set(input logic [ADDR_W-1:0] a);
        return |a[ADDR_W-1:ADDR_OK_W];
    endfunction

endpackage

// File: rtl/crc32c_desc_check.sv
module crc32c_desc_check
    import crc32c_pkg::*;
(
    input  desc_t d,
    output logic  ok,
    output mode_e mode,
    output logic  inl
);
    logic st, te, unknown, flag_bad, addr_bad;

    always_comb begin
        st       = d.flags[FB_STORE];
        te       = d.flags[FB_TEST];
        inl      = d.flags[FB_INLINE];
        unknown  = |(d.flags & ~FLAG_KNOWN);
        flag_bad = (st && te) || (inl && !st && !te) || unknown;
        addr_bad = addr_high_set(d.src)
                 || (d.copy && addr_high_set(d.dst))
                 || (!inl && addr_high_set(d.res));
        ok       = !flag_bad && !addr_bad;
        if (st)      mode = MODE_STORE;
        else if (te) mode = MODE_TEST;
        else         mode = MODE_ACCUM;
    end
endmodule

// File: rtl/crc32c_accum.sv
module crc32c_accum
    import crc32c_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             load_seed,
    input  logic [CRC_W-1:0] seed,
    input  logic             upd,
    input  logic [7:0]       data_byte,
    output logic [CRC_W-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || restart) crc <= CRC_INIT;
        else if (load_seed) crc <= seed;
        else if (upd)       crc <= crc32c_byte(crc, data_byte);
    end

    AST_SEED_LOADED: assert property (@(posedge clk) disable iff (rst)
        (load_seed && !restart) |=> (crc == $past(seed))); // R6
endmodule

// File: rtl/crc32c_result.sv
module crc32c_result
    import crc32c_pkg::*;
#(
    parameter int CNT_W = 16
)(
    input  logic [CRC_W-1:0]  crc_raw,
    input  logic [CRC_W-1:0]  cmp_word,
    input  logic              copy,
    input  logic              inl,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [ADDR_W-1:0] res,
    input  logic [CNT_W-1:0]  count,
    output logic [CRC_W-1:0]  crc_fin,
    output logic              match,
    output logic [ADDR_W-1:0] tgt_addr
);
    logic [ADDR_W-1:0] base;

    always_comb begin
        crc_fin  = crc_raw ^ CRC_XOROUT;
        match    = (crc_fin == cmp_word);
        base     = copy ? dst : src;
        tgt_addr = inl ? (base + {{(ADDR_W-CNT_W){1'b0}}, count}) : res;
    end
endmodule

// File: rtl/crc32c_desc_unit.sv
module crc32c_desc_unit
    import crc32c_pkg::*;
#(
    parameter int CNT_W = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [FLAG_W-1:0] desc_flags,
    input  logic              desc_copy,
    input  logic              desc_seed_valid,
    input  logic [CRC_W-1:0]  desc_seed,
    input  logic [ADDR_W-1:0] desc_src,
    input  logic [ADDR_W-1:0] desc_dst,
    input  logic [ADDR_W-1:0] desc_res,
    input  logic [CRC_W-1:0]  desc_exp,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              done,
    output logic [1:0]        status,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_addr,
    output logic [CRC_W-1:0]  res_crc
);
    typedef enum logic [2:0] {S_IDLE, S_DATA, S_EXP, S_FIN, S_REJ} state_e;

    state_e            state;
    desc_t             d_in;
    logic              d_ok, d_inl;
    mode_e             d_mode;
    mode_e             mode_q;
    logic              inl_q, copy_q;
    logic [ADDR_W-1:0] src_q, dst_q, res_q;
    logic [CRC_W-1:0]  expw_q, exps_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        nexp_q;
    logic [CRC_W-1:0]  crc_raw, crc_fin, cmp_word;
    logic              match, accept, take, restart, load_seed;
    logic [ADDR_W-1:0] tgt_addr;
    status_e           status_w;

    assign d_in = '{flags: desc_flags, copy: desc_copy,
                    src: desc_src, dst: desc_dst, res: desc_res};

    crc32c_desc_check u_check (
        .d    (d_in),
        .ok   (d_ok),
        .mode (d_mode),
        .inl  (d_inl)
    );

    assign desc_ready = (state == S_IDLE);
    assign in_ready   = (state == S_DATA) || (state == S_EXP);
    assign accept     = desc_valid && desc_ready;
    assign take       = in_valid && in_ready;
    assign load_seed  = accept && d_ok && desc_seed_valid;
    assign restart    = (state == S_FIN) && (mode_q != MODE_ACCUM);

    crc32c_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .load_seed (load_seed),
        .seed      (desc_seed),
        .upd       (take && (state == S_DATA)),
        .data_byte (in_data),
        .crc       (crc_raw)
    );

    assign cmp_word = inl_q ? exps_q : expw_q;

    crc32c_result #(.CNT_W(CNT_W)) u_result (
        .crc_raw  (crc_raw),
        .cmp_word (cmp_word),
        .copy     (copy_q),
        .inl      (inl_q),
        .src      (src_q),
        .dst      (dst_q),
        .res      (res_q),
        .count    (cnt_q),
        .crc_fin  (crc_fin),
        .match    (match),
        .tgt_addr (tgt_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            mode_q <= MODE_ACCUM;
            inl_q  <= 1'b0;
            copy_q <= 1'b0;
            src_q  <= '0;
            dst_q  <= '0;
            res_q  <= '0;
            expw_q <= '0;
            exps_q <= '0;
            cnt_q  <= '0;
            nexp_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (accept) begin
                    mode_q <= d_mode;
                    inl_q  <= d_inl;
                    copy_q <= desc_copy;
                    src_q  <= desc_src;
                    dst_q  <= desc_dst;
                    res_q  <= desc_res;
                    expw_q <= desc_exp;
                    cnt_q  <= '0;
                    nexp_q <= '0;
                    state  <= d_ok ? S_DATA : S_REJ;
                end
                S_DATA: if (take) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (in_last)
                        state <= (mode_q == MODE_TEST && inl_q) ? S_EXP : S_FIN;
                end
                S_EXP: if (take) begin
                    exps_q <= {in_data, exps_q[CRC_W-1:8]};
                    nexp_q <= nexp_q + 2'd1;
                    if (nexp_q == 2'd3) state <= S_FIN;
                end
                S_FIN:   state <= S_IDLE;
                S_REJ:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        status_w = ST_OK;
        if (state == S_REJ)
            status_w = ST_REJECT;
        else if (state == S_FIN && mode_q == MODE_TEST && !match)
            status_w = ST_MISMATCH;
    end

    assign done      = (state == S_FIN) || (state == S_REJ);
    assign status    = status_w;
    assign res_valid = (state == S_FIN) && (mode_q == MODE_STORE);
    assign res_addr  = tgt_addr;
    assign res_crc   = crc_fin;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(desc_ready && in_ready)); // R11
    AST_REJ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (done && status == ST_REJECT) |-> $past(desc_valid && desc_ready)); // R4
    AST_REJ_KEEPS_CRC: assert property (@(posedge clk) disable iff (rst)
        (done && status == ST_REJECT) |-> $stable(crc_raw)); // R4
    AST_MISMATCH_TEST: assert property (@(posedge clk) disable iff (rst)
        (done && status == ST_MISMATCH) |-> (mode_q == MODE_TEST)); // R9
    AST_RES_WITH_OK: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (done && status == ST_OK)); // R7
    AST_REINIT: assert property (@(posedge clk) disable iff (rst)
        (done && status != ST_REJECT && mode_q != MODE_ACCUM) |=> (crc_raw == CRC_INIT)); // R10
endmodule

// File: tb/crc32c_desc_unit_bench.sv
module crc32c_desc_unit_bench;
    localparam logic [63:0] SRC_A = 64'h0000_0012_3400_0000;
    localparam logic [63:0] DST_A = 64'h0000_00AB_0000_1000;
    localparam logic [63:0] RES_A = 64'h0000_0000_00C0_FFEE;
    localparam int NV = 16;

    // {flags, copy, seedv, src_bad, dst_bad, res_bad, wrong, len, base, seed, status}
    localparam logic [61:0] TBL [NV] = '{
        {6'h08, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd9, 8'h31, 32'h0, 2'd0},
        {6'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5, 8'h31, 32'h0, 2'd0},
        {6'h28, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4, 8'h36, 32'h0, 2'd0},
        {6'h10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd7, 8'h10, 32'h12345678, 2'd0},
        {6'h30, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd6, 8'h40, 32'h0, 2'd2},
        {6'h37, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8, 8'h55, 32'h0, 2'd0},
        {6'h18, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3, 8'h01, 32'h0, 2'd1},
        {6'h20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3, 8'h01, 32'h0, 2'd1},
        {6'h08, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3, 8'h01, 32'h0, 2'd1},
        {6'h08, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3, 8'h70, 32'h0, 2'd0},
        {6'h08, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3, 8'h01, 32'h0, 2'd1},
        {6'h28, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd5, 8'h80, 32'h0, 2'd0},
        {6'h08, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd3, 8'h01, 32'h0, 2'd1},
        {6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3, 8'h90, 32'h0, 2'd0},
        {6'h18, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3, 8'h01, 32'h0, 2'd1},
        {6'h08, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2, 8'hA0, 32'h0, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_valid = 1'b0;
    logic        desc_ready;
    logic [5:0]  desc_flags = '0;
    logic        desc_copy = 1'b0;
    logic        desc_seed_valid = 1'b0;
    logic [31:0] desc_seed = '0;
    logic [63:0] desc_src = '0, desc_dst = '0, desc_res = '0;
    logic [31:0] desc_exp = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        done;
    logic [1:0]  status;
    logic        res_valid;
    logic [63:0] res_addr;
    logic [31:0] res_crc;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [31:0] m_crc = 32'hFFFF_FFFF;

    always #4 clk = ~clk;

    crc32c_desc_unit u_crc32c_desc_unit (
        .clk(clk), .rst(rst),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_flags(desc_flags), .desc_copy(desc_copy),
        .desc_seed_valid(desc_seed_valid), .desc_seed(desc_seed),
        .desc_src(desc_src), .desc_dst(desc_dst), .desc_res(desc_res),
        .desc_exp(desc_exp),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .done(done), .status(status), .res_valid(res_valid),
        .res_addr(res_addr), .res_crc(res_crc)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [31:0] model_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'h82F63B78) : (r >> 1);
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, input logic last);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = last;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    initial begin
        logic [61:0] e;
        logic [5:0]  fl;
        logic        cp, sv, sb, db, rb, wr;
        logic [7:0]  ln, bs;
        logic [31:0] sd, fin, expw;
        logic [1:0]  est;
        logic [63:0] eaddr;
        logic        is_st, is_te, is_in, seen_res, got_done;
        logic [1:0]  got_st;
        logic [63:0] got_addr;
        logic [31:0] got_crc;
        string       tag;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(desc_ready == 1'b1, "R11 idle after reset", {63'h0, desc_ready}, 64'h1);
        chk(done == 1'b0 && in_ready == 1'b0 && res_valid == 1'b0, "R11 outputs low after reset",
            {61'h0, done, in_ready, res_valid}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            e  = TBL[i];
            fl = e[61:56]; cp = e[55]; sv = e[54]; sb = e[53]; db = e[52]; rb = e[51]; wr = e[50];
            ln = e[49:42]; bs = e[41:34]; sd = e[33:2]; est = e[1:0];
            is_st = fl[3]; is_te = fl[4]; is_in = fl[5];
            if (est == 2'd1) tag = (sb || db || rb) ? "R5 reject" : "R4 reject";
            else if (is_te)  tag = sv ? "R6 seeded test" : (fl[0] ? "R3 generic flags test" : "R9 test");
            else if (is_st)  tag = is_in ? "R8 inline store" : "R7 store";
            else             tag = "R2 accumulate";

            // model
            fin = 32'h0;
            if (est != 2'd1) begin
                if (sv) m_crc = sd;
                for (int j = 0; j < int'(ln); j++) m_crc = model_byte(m_crc, bs + 8'(j));
                fin = m_crc ^ 32'hFFFF_FFFF;
                if (is_st || is_te) m_crc = 32'hFFFF_FFFF;
            end
            expw  = wr ? (fin ^ 32'h0000_0100) : fin;
            eaddr = is_in ? ((cp ? DST_A : SRC_A) + {56'h0, ln}) : RES_A;

            desc_flags = fl; desc_copy = cp; desc_seed_valid = sv; desc_seed = sd;
            desc_src = SRC_A | (sb ? 64'h0000_0100_0000_0000 : 64'h0);
            desc_dst = DST_A | (db ? 64'h8000_0000_0000_0000 : 64'h0);
            desc_res = RES_A | (rb ? 64'h0004_0000_0000_0000 : 64'h0);
            desc_exp = is_in ? 32'h0 : expw;
            desc_valid = 1'b1;
            while (!desc_ready) @(negedge clk);
            @(negedge clk);
            desc_valid = 1'b0;

            if (est != 2'd1) begin
                chk(desc_ready == 1'b0, {tag, " R11 busy during data"}, {63'h0, desc_ready}, 64'h0);
                for (int j = 0; j < int'(ln); j++) put_byte(bs + 8'(j), j == int'(ln) - 1);
                if (is_te && is_in)
                    for (int j = 0; j < 4; j++) put_byte(expw[8*j +: 8], j == 3);
            end

            got_done = 1'b0; seen_res = 1'b0; got_st = 2'd3; got_addr = '0; got_crc = '0;
            for (int w = 0; w < 40 && !got_done; w++) begin
                if (done) begin
                    got_done = 1'b1; got_st = status; seen_res = res_valid;
                    got_addr = res_addr; got_crc = res_crc;
                end else @(negedge clk);
            end
            chk(got_done, {tag, " R10 done seen"}, {63'h0, got_done}, 64'h1);
            chk(got_st == est, {tag, " R10 status"}, {62'h0, got_st}, {62'h0, est});
            @(negedge clk);
            chk(done == 1'b0, {tag, " R10 one-cycle done"}, {63'h0, done}, 64'h0);
            if (est == 2'd1)
                chk(in_ready == 1'b0, {tag, " R4 no bytes taken"}, {63'h0, in_ready}, 64'h0);

            if (est == 2'd0 && is_st) begin
                chk(seen_res == 1'b1, {tag, " result valid"}, {63'h0, seen_res}, 64'h1);
                chk(got_addr == eaddr, {tag, " result address"}, got_addr, eaddr);
                chk(got_crc == fin, {tag, " R1 result value"}, {32'h0, got_crc}, {32'h0, fin});
                if (i == 0 || i == 2)
                    chk(got_crc == 32'hE306_9283, "R1 R2 check value 123456789",
                        {32'h0, got_crc}, 64'hE306_9283);
            end else begin
                chk(seen_res == 1'b0, {tag, " no result"}, {63'h0, seen_res}, 64'h0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule